// File: doc/BRIEF.md
# Serial EEPROM Identifier Loader

After reset this block fetches a vendor identifier, a product identifier and a port-power grouping flag from a small three-wire serial EEPROM. It drives a read command on one bidirectional data wire, hands that wire over to the EEPROM after the command, clocks in three consecutive 16-bit words, and then releases both the clock and the data pins so that other logic can share the memory. A one-cycle done pulse marks the moment the decoded values are valid. From then on they stay fixed.

When the memory-enable strap is high, the block does not access the EEPROM. It reports built-in default identifiers and reads the grouping flag straight from the shared data pin, which then serves as a plain strap input. The serial clock runs at the system clock divided by a power-of-two parameter. The default of 64 turns a 48 MHz system clock into about 750 kHz.

Top module: `eeprom_id_loader`

## Requirements
- R1: The EEPROM is read once per reset, and only when `ext_mem_n` is low (0 = memory enabled). After `done` the serial clock is never enabled again until the next reset.
- R2: The block drives nine command bits on `sda_o` with `sda_oe` high, one per serial-clock period. In order they are 1 (start), 1, 0 (read opcode), then six address zeros. Each bit changes only while `sclk_o` is low, so it is stable at every rising edge.
- R3: After the ninth command bit, `sda_oe` goes low while the serial clock keeps running. The block samples `sda_i` once per serial-clock period, late in the high phase. The first sample is a dummy bit and is discarded.
- R4: After the 48th data bit, `sclk_oe` and `sda_oe` are both low and `done` pulses.
- R5: The 48 data bits arrive most significant bit first as words w0, w1, w2. `ganged` = w0 bit 14, `vendor_id` = w1 (high byte in bits 15..8), `product_id` = w2.
- R6: `pull_en` is high exactly while `ext_mem_n` is low, in every phase, including after the read.
- R7: With `ext_mem_n` high, no serial-clock edge occurs and `done` pulses after the first clock edge following reset release. `vendor_id`/`product_id` show `DEF_VID`/`DEF_PID` (defaults 16'hC0DE/16'h0004), and `ganged` follows `sda_i`.
- R8: `done` is high for exactly one cycle, and `vendor_id`/`product_id` do not change after it.
- R9: The serial clock period is `CLK_DIV` system clocks (default 64). The low half comes first in each period.
- R10: In read mode, `done` is first high after clock edge 1 + (9 + 1 + 48) x `CLK_DIV` after reset release (3713 by default). During reset, `done`, `sclk_oe`, `sda_oe`, `vendor_id` and `product_id` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_mem_n | input | 1 | Memory-enable strap, 0 = read the EEPROM |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock output enable |
| sda_i | input | 1 | Data pin input value, or grouping strap in bypass mode |
| sda_o | output | 1 | Data pin drive value |
| sda_oe | output | 1 | Data pin output enable |
| pull_en | output | 1 | Weak pulldown enable for both pins |
| ganged | output | 1 | Port-power grouping flag |
| vendor_id | output | 16 | Vendor identifier |
| product_id | output | 16 | Product identifier |
| done | output | 1 | One-cycle pulse when the identifiers are valid |

## Verification
The bench counts clock edges from reset release. It expects `done` after edge 3713 in read mode and after edge 1 in bypass mode. The scoreboard monitor compares that count, together with the decoded fields, at the falling edge of the system clock in the cycle where `done` is high, and checks that `done` is low one cycle later. An EEPROM model captures the command bits and drives new data one clock tick after each serial-clock rising edge. It measures the 64-cycle spacing of those edges and sees the data line released when the dummy bit is due. Pin release, the stability of the identifiers and the bypass strap are checked 20 to 100 cycles after `done`, when nothing is pending.

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader #(
  parameter int CLK_DIV = 64,
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 3,
  parameter logic [WORD_W-1:0] DEF_VID = 16'hC0DE,
  parameter logic [WORD_W-1:0] DEF_PID = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mem_n,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              pull_en,
  output logic              ganged,
  output logic [WORD_W-1:0] vendor_id,
  output logic [WORD_W-1:0] product_id,
  output logic              done
);
  localparam int DIV_W     = $clog2(CLK_DIV);
  localparam int CMD_BITS  = 3 + ADDR_W;
  localparam int DATA_BITS = N_WORDS * WORD_W;
  localparam int N_SLOTS   = CMD_BITS + 1 + DATA_BITS;
  localparam int SLOT_W    = $clog2(N_SLOTS + 1);
  localparam int GANG_IDX  = DATA_BITS - 2;
  localparam logic [CMD_BITS-1:0] CMD = {3'b110, {ADDR_W{1'b0}}};

  logic                 pend, busy, gang_q;
  logic [DIV_W-1:0]     div;
  logic [SLOT_W-1:0]    slot;
  logic [CMD_BITS-1:0]  cmd_sr;
  logic [DATA_BITS-1:0] sh;
  logic [WORD_W-1:0]    vid_q, pid_q;

  wire tick   = busy && (div == DIV_W'(CLK_DIV - 1));
  wire last   = slot == SLOT_W'(N_SLOTS - 1);
  wire in_cmd = slot < SLOT_W'(CMD_BITS);
  wire [DATA_BITS-1:0] sh_nx = {sh[DATA_BITS-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
      div    <= '0;
      slot   <= '0;
      cmd_sr <= CMD;
      sh     <= '0;
      gang_q <= 1'b0;
      vid_q  <= '0;
      pid_q  <= '0;
    end else begin
      done <= 1'b0;
      if (pend) begin
        pend <= 1'b0;
        if (ext_mem_n) begin
          done  <= 1'b1;
          vid_q <= DEF_VID;
          pid_q <= DEF_PID;
        end else begin
          busy <= 1'b1;
        end
      end
      if (busy) begin
        div <= div + 1'b1;
        if (tick) begin
          slot   <= slot + 1'b1;
          cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
          if (slot > SLOT_W'(CMD_BITS)) sh <= sh_nx;
          if (last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            gang_q <= sh_nx[GANG_IDX];
            vid_q  <= sh_nx[DATA_BITS-WORD_W-1 -: WORD_W];
            pid_q  <= sh_nx[DATA_BITS-2*WORD_W-1 -: WORD_W];
          end
        end
      end
    end
  end

  assign sclk_oe    = busy;
  assign sclk_o     = busy & div[DIV_W-1];
  assign sda_oe     = busy & in_cmd;
  assign sda_o      = sda_oe & cmd_sr[CMD_BITS-1];
  assign pull_en    = ~ext_mem_n;
  assign ganged     = ext_mem_n ? sda_i : gang_q;
  assign vendor_id  = vid_q;
  assign product_id = pid_q;
endmodule

module eeprom_id_loader_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_oe,
  input logic              sda_oe,
  input logic              pull_en,
  input logic              done,
  input logic [WORD_W-1:0] vendor_id,
  input logic [WORD_W-1:0] product_id
);
  logic seen_done;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_done <= 1'b0;
    else if (done) seen_done <= 1'b1;

  // R1
  no_second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> !sclk_oe);
  // R2
  data_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> sclk_oe);
  // R3
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> sclk_oe);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk_oe && !sda_oe));
  // R6
  pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> pull_en);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  ids_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> ($stable(vendor_id) && $stable(product_id)));
endmodule

bind eeprom_id_loader eeprom_id_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_oe(sclk_oe), .sda_oe(sda_oe),
  .pull_en(pull_en), .done(done), .vendor_id(vendor_id), .product_id(product_id)
);

// File: tb/eeprom_id_loader_bench.sv
module eeprom_id_loader_bench;
  logic clk = 0, rst_n = 0, ext_mem_n = 0, gpin = 0, mdl_q = 0;
  logic sclk_o, sclk_oe, sda_o, sda_oe, pull_en, ganged, done;
  logic [15:0] vendor_id, product_id;
  logic sda_i;
  assign sda_i = ext_mem_n ? gpin : mdl_q;

  eeprom_id_loader u_eeprom_id_loader (
    .clk(clk), .rst_n(rst_n), .ext_mem_n(ext_mem_n), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sda_i(sda_i), .sda_o(sda_o), .sda_oe(sda_oe),
    .pull_en(pull_en), .ganged(ganged), .vendor_id(vendor_id),
    .product_id(product_id), .done(done));

  always #10 clk = ~clk;

  typedef struct { logic g; logic [15:0] vid; logic [15:0] pid; int lat; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic [47:0] mem_bits;
  logic [8:0] cmd_cap;
  int rise_k, last_rise;
  logic after_done = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // EEPROM model
  always @(posedge sclk_o or negedge rst_n) begin
    if (!rst_n) begin
      rise_k = 0; cmd_cap = '0; mdl_q = 0; last_rise = 0;
    end else begin
      #1;
      if (rise_k == 0) chk(pull_en == 1'b1, "R6", pull_en, 1);
      if (rise_k == 1) chk(cyc - last_rise == 64, "R9", cyc - last_rise, 64);
      last_rise = cyc;
      if (rise_k < 9) cmd_cap = {cmd_cap[7:0], sda_o};
      else begin
        if (rise_k == 9) chk(sda_oe == 1'b0 && sclk_oe == 1'b1, "R3", sda_oe, 0);
        if (rise_k == 9 || rise_k > 57) mdl_q = 1'b0;
        else mdl_q = mem_bits[57 - rise_k];
      end
      rise_k++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (after_done) begin
      chk(done == 1'b0, "R8", done, 0);
      after_done <= 0;
    end
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.lat, "R10", cyc, e.lat);
        chk(ganged == e.g, "R5", ganged, e.g);
        chk(vendor_id == e.vid, "R5", vendor_id, e.vid);
        chk(product_id == e.pid, "R5", product_id, e.pid);
      end
      after_done <= 1;
    end
  end

  task automatic run_case(input logic ext, input logic [15:0] w0, w1, w2);
    exp_t e;
    logic [15:0] v;
    int n;
    mem_bits = {w0, w1, w2};
    e.g   = ext ? gpin : w0[14];
    e.vid = ext ? 16'hC0DE : w1;
    e.pid = ext ? 16'h0004 : w2;
    e.lat = ext ? 1 : 3713;
    exp_q.push_back(e);
    rst_n = 0;
    ext_mem_n = ext;
    repeat (4) @(negedge clk);
    chk(done == 0 && sclk_oe == 0 && sda_oe == 0 && vendor_id == 0 && product_id == 0,
        "R10", {done, sclk_oe, sda_oe}, 0);
    rst_n = 1;
    n = 0;
    while (!done && n < 6000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R4", 0, 1);
    repeat (20) @(negedge clk);
    chk(sclk_oe == 0 && sda_oe == 0, "R4", {sclk_oe, sda_oe}, 0);
    chk(pull_en == !ext, "R6", pull_en, !ext);
    v = vendor_id;
    repeat (100) @(negedge clk);
    chk(vendor_id == v && sclk_oe == 0, "R8", vendor_id, v);
    if (ext) begin
      chk(rise_k == 0, "R7", rise_k, 0);
      gpin = ~gpin; @(negedge clk);
      chk(ganged == gpin, "R7", ganged, gpin);
      gpin = ~gpin; @(negedge clk);
      chk(ganged == gpin, "R7", ganged, gpin);
    end else begin
      chk(cmd_cap == 9'b110000000, "R2", cmd_cap, 9'b110000000);
      chk(rise_k == 58, "R1", rise_k, 58);
    end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    run_case(1'b0, 16'h4000, 16'hBEEF, 16'h0123);
    run_case(1'b0, 16'hBFFF, 16'h8001, 16'hFFFE);
    gpin = 1;
    run_case(1'b1, 16'h0000, 16'h0000, 16'h0000);
    gpin = 0;
    run_case(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run_case(1'b0, 16'h7FFF, 16'h0451, 16'h2A5A);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule